// File: doc/BRIEF.md
# Transmitter Margining Segment Controller

This block produces the digital controls for a segmented differential transmit driver with five FIR taps: one pre-cursor, one main and three post-cursor. Each tap is built from three segments. The data segment carries half of the tap current. An offset segment and a common-mode segment share the other half. For each segment the block decides two things: whether it follows the serial data, or whether one or both of its differential inputs are forced high. It also sets the tail-current code of each segment.

In the two margining modes, the transmitter places a DC differential offset of chosen sign and size on the line while the common mode stays fixed, which makes an in-situ eye scan possible.
- In write margining, the local data still flows through the data segment.
- In read margining, the data segment is switched off. The offset is then added on top of the far end's half-swing signal, so the offset and common-mode currents are scaled down to 2/3 (rounded toward zero).

A new setting of mode, sign, magnitude and ratio is captured only on a commit strobe. The segment controls therefore change at one clean clock edge and never part-way through a pattern.

Top module: `tx_margin_seg_ctrl`

## Requirements
- R1: After synchronous active-low reset, the committed state is: normal mode, positive sign, magnitude 0, unscaled. Every segment is data-enabled with no forced input. The data code is HALF_FS (32), the offset code is 0 and the common-mode code is 32.
- R2: While `commit` is low, changes on `mode`, `off_sign`, `off_mag` and `ratio_sel` leave every output unchanged.
- R3: When `commit` is high at a rising clock edge with a legal mode, the outputs show the sampled setting right after that edge. A `commit` held high re-captures the inputs at every edge.
- R4: Mode 2'b00 (normal write): all three segments of every tap are data-enabled (`seg_data_en` bit 3*t+s, where s=0 is data, s=1 is offset and s=2 is common mode), and no input is forced.
- R5: Mode 2'b01 (write margining): only the data segment is data-enabled. With `off_sign`=0 the offset segment forces its P input only, and with `off_sign`=1 it forces its N input only. The common-mode segment forces both inputs.
- R6: Mode 2'b10 (read margining): the data segment is neither enabled nor forced, and its code is 0. The offset and common-mode segments are forced as in R5.
- R7: In modes 00 and 01, the data code is HALF_FS. The offset code is min(`off_mag`, HALF_FS), and the common-mode code is HALF_FS minus the offset code, so their sum stays at 32.
- R8: In mode 10 with `ratio_sel`=1, the offset code is floor(2*min(`off_mag`,32)/3) and the common-mode code is floor(2*32/3)=21 minus that value. With `ratio_sel`=0 the codes follow R7.
- R9: A commit with the reserved mode 2'b11 is dropped as a whole: mode, sign, magnitude and ratio all keep their previous committed values.
- R10: All five taps receive identical segment controls and codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit | input | 1 | Capture strobe for the setting inputs |
| mode | input | 2 | 00 normal, 01 write margin, 10 read margin, 11 reserved |
| off_sign | input | 1 | Offset polarity, 0 forces the P side |
| off_mag | input | 6 | Requested offset magnitude code |
| ratio_sel | input | 1 | 1 scales read-margin currents by 2/3 |
| seg_data_en | output | 15 | Data enable per segment, bit 3*tap+seg |
| seg_force_p | output | 15 | Force P input high per segment |
| seg_force_n | output | 15 | Force N input high per segment |
| tap_data_code | output | 30 | Data-segment tail code per tap, 6 bits each |
| tap_off_code | output | 30 | Offset-segment tail code per tap |
| tap_cm_code | output | 30 | Common-mode-segment tail code per tap |

## Verification
The functions that can fall in the same cycle are the commit capture and a change of the setting inputs. The bench provokes this in three ways: it holds `commit` high while mode, sign and magnitude move at every clock; it lowers `commit` in the same cycle the inputs change; and it commits the reserved mode while the other fields carry new values. A behavioural model keeps its own copy of the committed setting, updates it only at edges where the strobe and a legal mode coincide, and its expected values are compared on every clock. This shows whether a capture took the fields of the right cycle, and whether a reserved-mode commit leaked any field.

// File: rtl/tx_mrg_pkg.sv
// Package: shared types for the transmit margining segment controller.
// Assumes three segments per tap in the fixed order data, offset, common mode.
package tx_mrg_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_WR_MRG = 2'b01,
        MODE_RD_MRG = 2'b10,
        MODE_RSVD   = 2'b11
    } mrg_mode_e;

    localparam int SEG_PER_TAP = 3;
    localparam int SEG_DATA    = 0;
    localparam int SEG_OFFS    = 1;
    localparam int SEG_CM      = 2;

endpackage

// File: rtl/tx_mrg_cfg_reg.sv
// Module: committed-setting register.
// Captures mode, sign, magnitude and ratio on the commit strobe. A commit
// carrying the reserved mode is discarded completely. Assumes commit is
// synchronous to clk.
module tx_mrg_cfg_reg
    import tx_mrg_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [1:0]        mode_in,
    input  logic              sign_in,
    input  logic [CODE_W-1:0] mag_in,
    input  logic              ratio_in,
    output mrg_mode_e         mode_q,
    output logic              sign_q,
    output logic [CODE_W-1:0] mag_q,
    output logic              ratio_q
);

    logic take;

    // Accept a commit only with a legal mode.
    always_comb begin
        take = commit && (mode_in != MODE_RSVD);
    end

    // Hold the committed setting, reset to normal mode with no offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_NORMAL;
            sign_q  <= 1'b0;
            mag_q   <= '0;
            ratio_q <= 1'b0;
        end else if (take) begin
            mode_q  <= mrg_mode_e'(mode_in);
            sign_q  <= sign_in;
            mag_q   <= mag_in;
            ratio_q <= ratio_in;
        end
    end

endmodule

// File: rtl/tx_mrg_code_calc.sv
// Module: tail-code calculator.
// Clamps the offset magnitude to the half-current full scale and derives
// the common-mode code so the pair sums to a constant. In read margining
// with the ratio select set, both are scaled by 2/3 rounding toward zero.
// Assumes HALF_FS fits in CODE_W bits.
module tx_mrg_code_calc
    import tx_mrg_pkg::*;
#(
    parameter int CODE_W  = 6,
    parameter int HALF_FS = 32
) (
    input  mrg_mode_e         mode,
    input  logic [CODE_W-1:0] mag,
    input  logic              ratio,
    output logic [CODE_W-1:0] data_code,
    output logic [CODE_W-1:0] off_code,
    output logic [CODE_W-1:0] cm_code
);

    localparam logic [CODE_W-1:0] HALF_C  = CODE_W'(HALF_FS);
    localparam logic [CODE_W-1:0] HALF_SC = CODE_W'((HALF_FS * 2) / 3);
    localparam int                WIDE_W  = CODE_W + 2;

    logic [CODE_W-1:0] clamped;
    logic [WIDE_W-1:0] doubled;
    logic [CODE_W-1:0] scaled;
    logic              use_scale;

    // Limit the requested magnitude to the segment full scale.
    always_comb begin
        clamped = (mag > HALF_C) ? HALF_C : mag;
    end

    // Two-thirds of the clamped value, fraction dropped.
    always_comb begin
        doubled = {1'b0, clamped, 1'b0};
        scaled  = CODE_W'(doubled / WIDE_W'(3));
    end

    // Choose codes from the committed mode.
    always_comb begin
        use_scale = (mode == MODE_RD_MRG) && ratio;
        data_code = (mode == MODE_RD_MRG) ? '0 : HALF_C;
        if (use_scale) begin
            off_code = scaled;
            cm_code  = HALF_SC - scaled;
        end else begin
            off_code = clamped;
            cm_code  = HALF_C - clamped;
        end
    end

endmodule

// File: rtl/tx_mrg_tap_drv.sv
// Module: per-tap segment router.
// Maps the committed mode and sign to data-enable and forced-input bits of
// the three segments of one tap, and passes the tail codes through.
// Assumes segment order data, offset, common mode in the 3-bit vectors.
module tx_mrg_tap_drv
    import tx_mrg_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  mrg_mode_e                mode,
    input  logic                     sign,
    input  logic [CODE_W-1:0]        data_code_in,
    input  logic [CODE_W-1:0]        off_code_in,
    input  logic [CODE_W-1:0]        cm_code_in,
    output logic [SEG_PER_TAP-1:0]   data_en,
    output logic [SEG_PER_TAP-1:0]   force_p,
    output logic [SEG_PER_TAP-1:0]   force_n,
    output logic [CODE_W-1:0]        data_code,
    output logic [CODE_W-1:0]        off_code,
    output logic [CODE_W-1:0]        cm_code
);

    // Route each segment according to mode.
    always_comb begin
        data_en = '0;
        force_p = '0;
        force_n = '0;
        unique case (mode)
            MODE_NORMAL: begin
                data_en = '1;
            end
            MODE_WR_MRG: begin
                data_en[SEG_DATA] = 1'b1;
                force_p[SEG_OFFS] = ~sign;
                force_n[SEG_OFFS] = sign;
                force_p[SEG_CM]   = 1'b1;
                force_n[SEG_CM]   = 1'b1;
            end
            MODE_RD_MRG: begin
                force_p[SEG_OFFS] = ~sign;
                force_n[SEG_OFFS] = sign;
                force_p[SEG_CM]   = 1'b1;
                force_n[SEG_CM]   = 1'b1;
            end
            default: begin
                data_en = '1;
            end
        endcase
    end

    // Pass the tail codes to this tap.
    always_comb begin
        data_code = data_code_in;
        off_code  = off_code_in;
        cm_code   = cm_code_in;
    end

endmodule

// File: rtl/tx_margin_seg_ctrl.sv
// Module: top of the transmit margining segment controller.
// Holds the committed setting, derives tail codes once, and fans them out
// to NUM_TAPS identical tap routers. Outputs come from registered state
// through combinational logic only, so they change only at a commit edge.
module tx_margin_seg_ctrl
    import tx_mrg_pkg::*;
#(
    parameter int NUM_TAPS = 5,
    parameter int CODE_W   = 6,
    parameter int HALF_FS  = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                commit,
    input  logic [1:0]                          mode,
    input  logic                                off_sign,
    input  logic [CODE_W-1:0]                   off_mag,
    input  logic                                ratio_sel,
    output logic [SEG_PER_TAP*NUM_TAPS-1:0]     seg_data_en,
    output logic [SEG_PER_TAP*NUM_TAPS-1:0]     seg_force_p,
    output logic [SEG_PER_TAP*NUM_TAPS-1:0]     seg_force_n,
    output logic [CODE_W*NUM_TAPS-1:0]          tap_data_code,
    output logic [CODE_W*NUM_TAPS-1:0]          tap_off_code,
    output logic [CODE_W*NUM_TAPS-1:0]          tap_cm_code
);

    mrg_mode_e         mode_q;
    logic              sign_q;
    logic [CODE_W-1:0] mag_q;
    logic              ratio_q;
    logic [CODE_W-1:0] data_c;
    logic [CODE_W-1:0] off_c;
    logic [CODE_W-1:0] cm_c;

    tx_mrg_cfg_reg #(.CODE_W(CODE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .mode_in  (mode),
        .sign_in  (off_sign),
        .mag_in   (off_mag),
        .ratio_in (ratio_sel),
        .mode_q   (mode_q),
        .sign_q   (sign_q),
        .mag_q    (mag_q),
        .ratio_q  (ratio_q)
    );

    tx_mrg_code_calc #(.CODE_W(CODE_W), .HALF_FS(HALF_FS)) u_calc (
        .mode      (mode_q),
        .mag       (mag_q),
        .ratio     (ratio_q),
        .data_code (data_c),
        .off_code  (off_c),
        .cm_code   (cm_c)
    );

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        tx_mrg_tap_drv #(.CODE_W(CODE_W)) u_tap (
            .mode         (mode_q),
            .sign         (sign_q),
            .data_code_in (data_c),
            .off_code_in  (off_c),
            .cm_code_in   (cm_c),
            .data_en      (seg_data_en[t*SEG_PER_TAP +: SEG_PER_TAP]),
            .force_p      (seg_force_p[t*SEG_PER_TAP +: SEG_PER_TAP]),
            .force_n      (seg_force_n[t*SEG_PER_TAP +: SEG_PER_TAP]),
            .data_code    (tap_data_code[t*CODE_W +: CODE_W]),
            .off_code     (tap_off_code[t*CODE_W +: CODE_W]),
            .cm_code      (tap_cm_code[t*CODE_W +: CODE_W])
        );
    end

endmodule

// File: rtl/tx_margin_seg_ctrl_chk.sv
// Module: assertion checker for tx_margin_seg_ctrl, attached by bind.
// Observes only the top-level ports.
module tx_margin_seg_ctrl_chk
    import tx_mrg_pkg::*;
#(
    parameter int NUM_TAPS = 5,
    parameter int CODE_W   = 6,
    parameter int HALF_FS  = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            commit,
    input logic [SEG_PER_TAP*NUM_TAPS-1:0] seg_data_en,
    input logic [SEG_PER_TAP*NUM_TAPS-1:0] seg_force_p,
    input logic [SEG_PER_TAP*NUM_TAPS-1:0] seg_force_n,
    input logic [CODE_W*NUM_TAPS-1:0]      tap_data_code,
    input logic [CODE_W*NUM_TAPS-1:0]      tap_off_code,
    input logic [CODE_W*NUM_TAPS-1:0]      tap_cm_code
);

    localparam int SUM_FULL = HALF_FS;
    localparam int SUM_SCL  = (HALF_FS * 2) / 3;

    // R2: without a commit on the previous edge nothing moves.
    p_hold_without_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(commit)) |->
        ($stable(seg_data_en) && $stable(seg_force_p) && $stable(seg_force_n) &&
         $stable(tap_data_code) && $stable(tap_off_code) && $stable(tap_cm_code)))
        else $error("p_hold_without_commit_r2");

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_chk
        // R4: a segment is never both data-driven and forced.
        p_en_force_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_data_en[t*3 +: 3] & (seg_force_p[t*3 +: 3] | seg_force_n[t*3 +: 3])) == 3'b000)
            else $error("p_en_force_excl_r4");

        // R5: offset segment forces at most one side; common-mode segment forces both or none.
        p_offset_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(seg_force_p[t*3 + SEG_OFFS] && seg_force_n[t*3 + SEG_OFFS]) &&
            (seg_force_p[t*3 + SEG_CM] == seg_force_n[t*3 + SEG_CM]))
            else $error("p_offset_one_side_r5");

        // R6: data code is zero exactly when the data segment is idle.
        p_data_code_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tap_data_code[t*CODE_W +: CODE_W] == '0) == !seg_data_en[t*3 + SEG_DATA])
            else $error("p_data_code_idle_r6");

        // R7 / R8: offset plus common-mode code is a constant full or scaled half.
        p_code_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((int'(tap_off_code[t*CODE_W +: CODE_W]) + int'(tap_cm_code[t*CODE_W +: CODE_W])) == SUM_FULL) ||
            ((int'(tap_off_code[t*CODE_W +: CODE_W]) + int'(tap_cm_code[t*CODE_W +: CODE_W])) == SUM_SCL))
            else $error("p_code_sum_r7");

        // R10: every tap matches tap 0.
        p_taps_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_data_en[t*3 +: 3] == seg_data_en[2:0]) &&
            (tap_off_code[t*CODE_W +: CODE_W] == tap_off_code[CODE_W-1:0]))
            else $error("p_taps_match_r10");
    end

endmodule

bind tx_margin_seg_ctrl tx_margin_seg_ctrl_chk #(
    .NUM_TAPS (NUM_TAPS),
    .CODE_W   (CODE_W),
    .HALF_FS  (HALF_FS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit),
    .seg_data_en   (seg_data_en),
    .seg_force_p   (seg_force_p),
    .seg_force_n   (seg_force_n),
    .tap_data_code (tap_data_code),
    .tap_off_code  (tap_off_code),
    .tap_cm_code   (tap_cm_code)
);

// File: tb/tx_margin_seg_ctrl_tb.sv
// Bench: behavioural reference model compared against the DUT on every clock.
module tx_margin_seg_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NT   = 5;
    localparam int CW   = 6;
    localparam int HALF = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            commit = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic            off_sign = 1'b0;
    logic [CW-1:0]   off_mag = '0;
    logic            ratio_sel = 1'b0;
    logic [3*NT-1:0] seg_data_en, seg_force_p, seg_force_n;
    logic [CW*NT-1:0] tap_data_code, tap_off_code, tap_cm_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit checking = 1'b0;
    string tag = "R1";

    // Model state.
    int m_mode = 0, m_sign = 0, m_mag = 0, m_ratio = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_margin_seg_ctrl #(.NUM_TAPS(NT), .CODE_W(CW), .HALF_FS(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .commit(commit), .mode(mode),
        .off_sign(off_sign), .off_mag(off_mag), .ratio_sel(ratio_sel),
        .seg_data_en(seg_data_en), .seg_force_p(seg_force_p), .seg_force_n(seg_force_n),
        .tap_data_code(tap_data_code), .tap_off_code(tap_off_code), .tap_cm_code(tap_cm_code)
    );

    // Reference model: committed setting updated at capturing edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_sign = 0; m_mag = 0; m_ratio = 0;
        end else if (commit && mode != 2'b11) begin
            m_mode = int'(mode); m_sign = int'(off_sign);
            m_mag = int'(off_mag); m_ratio = int'(ratio_sel);
        end
    end

    // Compare every output of every tap against the model.
    always @(negedge clk) begin
        if (checking) begin
            int c, e_d, e_o, e_c;
            logic [2:0] e_en, e_fp, e_fn;
            bit bad;
            c = (m_mag > HALF) ? HALF : m_mag;
            e_d = (m_mode == 2) ? 0 : HALF;
            if (m_mode == 2 && m_ratio == 1) begin
                e_o = (2 * c) / 3; e_c = (2 * HALF) / 3 - e_o;
            end else begin
                e_o = c; e_c = HALF - c;
            end
            if (m_mode == 0) begin
                e_en = 3'b111; e_fp = 3'b000; e_fn = 3'b000;
            end else begin
                e_en = (m_mode == 1) ? 3'b001 : 3'b000;
                e_fp = {1'b1, (m_sign == 0), 1'b0};
                e_fn = {1'b1, (m_sign == 1), 1'b0};
            end
            bad = 1'b0;
            for (int t = 0; t < NT; t++) begin
                if (seg_data_en[t*3 +: 3] != e_en || seg_force_p[t*3 +: 3] != e_fp ||
                    seg_force_n[t*3 +: 3] != e_fn) begin
                    $display("FAIL %s tap%0d seg en/fp/fn got %b/%b/%b exp %b/%b/%b", tag, t,
                             seg_data_en[t*3 +: 3], seg_force_p[t*3 +: 3], seg_force_n[t*3 +: 3],
                             e_en, e_fp, e_fn);
                    bad = 1'b1;
                end
                if (int'(tap_data_code[t*CW +: CW]) != e_d || int'(tap_off_code[t*CW +: CW]) != e_o ||
                    int'(tap_cm_code[t*CW +: CW]) != e_c) begin
                    $display("FAIL %s tap%0d codes d/o/c got %0d/%0d/%0d exp %0d/%0d/%0d", tag, t,
                             tap_data_code[t*CW +: CW], tap_off_code[t*CW +: CW],
                             tap_cm_code[t*CW +: CW], e_d, e_o, e_c);
                    bad = 1'b1;
                end
            end
            checks++;
            if (bad) failures++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog cycles=%0d expected<=50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input string t, input bit cm, input int md, input int sg,
                        input int mg, input int rt, input int n);
        @(negedge clk);
        tag = t; commit = cm; mode = 2'(md); off_sign = sg[0];
        off_mag = CW'(mg); ratio_sel = rt[0];
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checking = 1'b1;            // R1 checked while and after reset
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: fields change with no commit.
        step("R2", 0, 1, 1, 20, 1, 2);
        step("R2", 0, 2, 0, 50, 1, 2);

        // R5 / R7: write margin, both signs, clamp at full scale.
        step("R5", 1, 1, 0, 10, 0, 1);
        step("R5", 0, 0, 1, 5, 0, 3);
        step("R7", 1, 1, 1, 40, 0, 1);
        step("R7", 0, 1, 1, 40, 0, 2);
        step("R7", 1, 1, 0, 32, 0, 1);
        step("R7", 1, 1, 0, 0, 0, 1);

        // R6 / R8: read margin, unscaled then scaled corner values.
        step("R6", 1, 2, 0, 12, 0, 1);
        step("R6", 0, 2, 0, 12, 0, 2);
        step("R8", 1, 2, 1, 31, 1, 2);
        step("R8", 1, 2, 0, 32, 1, 2);
        step("R8", 1, 2, 0, 63, 1, 2);
        step("R8", 1, 2, 1, 1, 1, 2);
        step("R8", 1, 2, 1, 0, 1, 2);
        step("R8", 1, 2, 1, 2, 1, 2);

        // R9: reserved mode commit with other fields changed.
        step("R9", 1, 3, 0, 7, 0, 3);

        // R4: back to normal write.
        step("R4", 1, 0, 1, 9, 1, 1);
        step("R4", 0, 0, 1, 9, 1, 2);

        // R3: commit held high while fields move each cycle.
        for (int i = 0; i < 24; i++) begin
            step("R3", 1, i % 4, (i / 2) % 2, (i * 7) % 64, (i / 3) % 2, 1);
        end
        // R3: commit dropped in the same cycle the fields change.
        step("R3", 0, 1, 1, 3, 0, 3);

        // R10: sweep all magnitudes over the legal modes.
        for (int m = 0; m < 64; m++) begin
            step("R10", 1, m % 3, m % 2, m, (m / 3) % 2, 1);
            step("R10", 0, 0, 0, 0, 0, 1);
        end

        // R1: reset again from a non-default setting.
        step("R1", 1, 2, 1, 20, 1, 1);
        @(negedge clk);
        rst_n = 1'b0;
        commit = 1'b0;
        repeat (3) @(negedge clk);

        checking = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule